// File: doc/BRIEF.md
# Two-Way Delay and Offset Estimator

The block turns the four hardware timestamps of one two-way exchange into a round-trip delay, a one-way delay estimate and a clock offset. The one-way estimate and the offset take programmed corrections into account: a fixed transmit latency, a fixed receive latency and a signed asymmetry term. The bare symmetric half of the round trip is therefore never what reaches the output. Timestamps are 64-bit unsigned counts of 1/16 ns. Every difference is formed as a 66-bit signed value, so the arithmetic cannot wrap.

Beside the per-sample results, the block groups strobes into measurement windows. The window length is a power of two. Inside a window it counts the usable samples and keeps the sum, the smallest and the largest round-trip delay. When the window closes it reports the mean and the spread, and it flags the window as fit for a servo only when two conditions hold: enough usable samples arrived, and the delay spread stayed inside a jitter limit. A sample with a negative round trip is treated as unusable. It uses up a slot of the window but adds nothing to the statistics.

Top module: `twoway_delay_est`

## Requirements
- R1: A strobe on `ts_valid` yields `s_valid` high in the next cycle, together with `s_rtt` = (t4 - t1) - (t3 - t2), computed as a 66-bit signed value.
- R2: `s_one_way` = (RTT - fixed_tx - fixed_rx - asym) shifted right arithmetically by one bit, which rounds toward minus infinity. The fixed terms are unsigned. The asymmetry term is two's complement.
- R3: `s_offset` = (t2 - t1) - one_way - fixed_tx - asym, computed as a 66-bit signed value.
- R4: A sample is usable (`s_good` = 1) exactly when its RTT is zero or positive. An unusable sample counts toward the window length but does not change the window count, sum, minimum or maximum.
- R5: A window ends with the 2^`cfg_win_log2`-th strobe. `win_done` is high for one cycle, during the second cycle after the cycle that presented that strobe.
- R6: A strobe presented in the cycle right after the closing strobe is the first strobe of the next window.
- R7: At `win_done`, the block reports: `win_count`, the number of usable samples; `win_min` and `win_max`, the extreme RTTs of those samples; `win_spread` = max - min; and `win_mean` = (sum of usable RTTs) >> `cfg_win_log2`. A window with no usable sample reports zero in all five fields.
- R8: `win_valid` is 1 only if `win_count` is nonzero and at least `cfg_min_good`.
- R9: `win_valid` is 0 when `win_spread` exceeds `cfg_jitter_max`. A spread equal to the limit is accepted.
- R10: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Timestamp set strobe |
| ts_t1 | input | TS_W | Request departure time |
| ts_t2 | input | TS_W | Request arrival time |
| ts_t3 | input | TS_W | Reply departure time |
| ts_t4 | input | TS_W | Reply arrival time |
| cfg_fixed_tx | input | CORR_W | Fixed transmit latency, unsigned |
| cfg_fixed_rx | input | CORR_W | Fixed receive latency, unsigned |
| cfg_asym | input | CORR_W | Path asymmetry, two's complement |
| cfg_win_log2 | input | LW | log2 of the window length in strobes |
| cfg_min_good | input | CNT_W | Minimum number of usable samples for a valid window |
| cfg_jitter_max | input | TS_W+1 | Largest delay spread accepted |
| s_valid | output | 1 | Per-sample results valid |
| s_good | output | 1 | Sample is usable |
| s_rtt | output | TS_W+2 | Round-trip delay, signed |
| s_one_way | output | TS_W+2 | Corrected one-way delay, signed |
| s_offset | output | TS_W+2 | Corrected clock offset, signed |
| win_done | output | 1 | Window summary strobe |
| win_valid | output | 1 | Window passed both gates |
| win_count | output | CNT_W | Usable samples in the window |
| win_mean | output | TS_W+1 | Mean RTT |
| win_min | output | TS_W+1 | Smallest RTT |
| win_max | output | TS_W+1 | Largest RTT |
| win_spread | output | TS_W+1 | max - min |

## Verification
The assertions assume three things about the inputs:
- The configuration does not change while a window is open.
- `cfg_win_log2` never exceeds `WIN_LOG2_MAX`.
- The corrected terms stay far from the 66-bit limits.

The stimulus respects all three. It reprograms the window length, the sample minimum and the jitter limit only after a window has closed and the bus has been idle for several cycles. It also keeps every timestamp and correction well inside range, while still exercising negative clock offsets, negative asymmetry and negative round trips.

// File: rtl/twoway_delay_est.sv
module twoway_delay_est #(
  parameter int TS_W         = 64,
  parameter int CORR_W       = 32,
  parameter int WIN_LOG2_MAX = 10,
  localparam int DW    = TS_W + 2,
  localparam int MW    = TS_W + 1,
  localparam int CNT_W = WIN_LOG2_MAX + 1,
  localparam int LW    = $clog2(WIN_LOG2_MAX + 1),
  localparam int SUM_W = MW + WIN_LOG2_MAX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ts_valid,
  input  logic [TS_W-1:0]       ts_t1,
  input  logic [TS_W-1:0]       ts_t2,
  input  logic [TS_W-1:0]       ts_t3,
  input  logic [TS_W-1:0]       ts_t4,
  input  logic [CORR_W-1:0]     cfg_fixed_tx,
  input  logic [CORR_W-1:0]     cfg_fixed_rx,
  input  logic [CORR_W-1:0]     cfg_asym,
  input  logic [LW-1:0]         cfg_win_log2,
  input  logic [CNT_W-1:0]      cfg_min_good,
  input  logic [MW-1:0]         cfg_jitter_max,
  output logic                  s_valid,
  output logic                  s_good,
  output logic signed [DW-1:0]  s_rtt,
  output logic signed [DW-1:0]  s_one_way,
  output logic signed [DW-1:0]  s_offset,
  output logic                  win_done,
  output logic                  win_valid,
  output logic [CNT_W-1:0]      win_count,
  output logic [MW-1:0]         win_mean,
  output logic [MW-1:0]         win_min,
  output logic [MW-1:0]         win_max,
  output logic [MW-1:0]         win_spread
);

  logic signed [DW-1:0] d41, d32, d21, rtt, ftx, frx, asym, corr, one_way, offset;

  assign d41  = $signed({2'b00, ts_t4}) - $signed({2'b00, ts_t1});
  assign d32  = $signed({2'b00, ts_t3}) - $signed({2'b00, ts_t2});
  assign d21  = $signed({2'b00, ts_t2}) - $signed({2'b00, ts_t1});
  assign rtt  = d41 - d32;
  assign ftx  = $signed({{(DW-CORR_W){1'b0}}, cfg_fixed_tx});
  assign frx  = $signed({{(DW-CORR_W){1'b0}}, cfg_fixed_rx});
  assign asym = $signed({{(DW-CORR_W){cfg_asym[CORR_W-1]}}, cfg_asym});
  assign corr = rtt - ftx - frx - asym;
  assign one_way = corr >>> 1;
  assign offset  = d21 - one_way - ftx - asym;

  logic          good;
  logic [MW-1:0] rtt_u;
  logic [CNT_W-1:0] win_len;

  assign good    = ~rtt[DW-1];
  assign rtt_u   = rtt[MW-1:0];
  assign win_len = CNT_W'(1) << cfg_win_log2;

  logic             closing;
  logic [CNT_W-1:0] cnt_all, cnt_good;
  logic [SUM_W-1:0] acc_sum;
  logic [MW-1:0]    acc_min, acc_max;

  logic [CNT_W-1:0] b_all, b_good, n_all, n_good;
  logic [SUM_W-1:0] b_sum, n_sum;
  logic [MW-1:0]    b_min, b_max, n_min, n_max;

  always_comb begin
    b_all  = closing ? '0 : cnt_all;
    b_good = closing ? '0 : cnt_good;
    b_sum  = closing ? '0 : acc_sum;
    b_min  = closing ? '1 : acc_min;
    b_max  = closing ? '0 : acc_max;
    n_all  = b_all;
    n_good = b_good;
    n_sum  = b_sum;
    n_min  = b_min;
    n_max  = b_max;
    if (ts_valid) begin
      n_all = b_all + CNT_W'(1);
      if (good) begin
        n_good = b_good + CNT_W'(1);
        n_sum  = b_sum + SUM_W'(rtt_u);
        if (rtt_u < b_min) n_min = rtt_u;
        if (rtt_u > b_max) n_max = rtt_u;
      end
    end
  end

  logic [MW-1:0] cur_spread, cur_mean;
  logic          cur_ok;

  assign cur_spread = (cnt_good == '0) ? '0 : acc_max - acc_min;
  assign cur_mean   = MW'(acc_sum >> cfg_win_log2);
  assign cur_ok     = (cnt_good != '0) && (cnt_good >= cfg_min_good) &&
                      (cur_spread <= cfg_jitter_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid    <= 1'b0;
      s_good     <= 1'b0;
      s_rtt      <= '0;
      s_one_way  <= '0;
      s_offset   <= '0;
      closing    <= 1'b0;
      cnt_all    <= '0;
      cnt_good   <= '0;
      acc_sum    <= '0;
      acc_min    <= '1;
      acc_max    <= '0;
      win_done   <= 1'b0;
      win_valid  <= 1'b0;
      win_count  <= '0;
      win_mean   <= '0;
      win_min    <= '0;
      win_max    <= '0;
      win_spread <= '0;
    end else begin
      s_valid <= ts_valid;
      if (ts_valid) begin
        s_good    <= good;
        s_rtt     <= rtt;
        s_one_way <= one_way;
        s_offset  <= offset;
      end
      closing  <= ts_valid && (n_all == win_len);
      cnt_all  <= n_all;
      cnt_good <= n_good;
      acc_sum  <= n_sum;
      acc_min  <= n_min;
      acc_max  <= n_max;
      win_done <= closing;
      if (closing) begin
        win_valid  <= cur_ok;
        win_count  <= cnt_good;
        win_mean   <= cur_mean;
        win_min    <= (cnt_good == '0) ? '0 : acc_min;
        win_max    <= acc_max;
        win_spread <= cur_spread;
      end
    end
  end

  p_sample_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> s_valid);

  p_done_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> $past(s_valid));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> win_count <= win_len);

  p_min_le_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_count != '0) |-> win_min <= win_max);

  p_mean_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_count == win_len) |-> (win_mean >= win_min && win_mean <= win_max));

  p_empty_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_count == '0) |-> (win_spread == '0 && !win_valid));

  p_valid_needs_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_valid) |-> (win_count >= cfg_min_good));

  p_valid_needs_spread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_valid) |-> (win_spread <= cfg_jitter_max));

endmodule

// File: tb/test_twoway_delay_est.sv
module test_twoway_delay_est;
  localparam int DW = 66;
  localparam int MW = 65;
  localparam int CNT_W = 11;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ts_valid = 1'b0;
  logic [63:0] ts_t1 = '0, ts_t2 = '0, ts_t3 = '0, ts_t4 = '0;
  logic [31:0] cfg_fixed_tx = 32'd40, cfg_fixed_rx = 32'd24;
  logic signed [31:0] cfg_asym = -32'sd6;
  logic [LW-1:0] cfg_win_log2 = 4'd2;
  logic [CNT_W-1:0] cfg_min_good = 11'd3;
  logic [MW-1:0] cfg_jitter_max = 65'd200;

  logic s_valid, s_good, win_done, win_valid;
  logic signed [DW-1:0] s_rtt, s_one_way, s_offset;
  logic [CNT_W-1:0] win_count;
  logic [MW-1:0] win_mean, win_min, win_max, win_spread;

  twoway_delay_est i_twoway_delay_est (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid),
    .ts_t1(ts_t1), .ts_t2(ts_t2), .ts_t3(ts_t3), .ts_t4(ts_t4),
    .cfg_fixed_tx(cfg_fixed_tx), .cfg_fixed_rx(cfg_fixed_rx), .cfg_asym(cfg_asym),
    .cfg_win_log2(cfg_win_log2), .cfg_min_good(cfg_min_good), .cfg_jitter_max(cfg_jitter_max),
    .s_valid(s_valid), .s_good(s_good), .s_rtt(s_rtt), .s_one_way(s_one_way), .s_offset(s_offset),
    .win_done(win_done), .win_valid(win_valid), .win_count(win_count), .win_mean(win_mean),
    .win_min(win_min), .win_max(win_max), .win_spread(win_spread)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit burst_mode = 1'b0;

  task automatic check(input string tag, input logic signed [79:0] act, input logic signed [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic signed [DW-1:0] q_rtt[$];
  bit pend = 1'b0;
  bit e_sv = 1'b0, e_good = 1'b0, e_done = 1'b0, e_wv = 1'b0;
  logic signed [DW-1:0] e_rtt = '0, e_ow = '0, e_off = '0;
  logic [79:0] e_cnt = '0, e_mean = '0, e_min = '0, e_max = '0, e_spr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_rtt.delete();
      pend = 1'b0; e_sv = 1'b0; e_done = 1'b0;
    end else begin
      logic signed [DW-1:0] r, c, sa;
      r  = ($signed({2'b00, ts_t4}) - $signed({2'b00, ts_t1})) -
           ($signed({2'b00, ts_t3}) - $signed({2'b00, ts_t2}));
      sa = {{34{cfg_asym[31]}}, cfg_asym};
      e_sv = ts_valid;
      if (ts_valid) begin
        c = r - $signed({34'd0, cfg_fixed_tx}) - $signed({34'd0, cfg_fixed_rx}) - sa;
        e_rtt  = r;
        e_ow   = c >>> 1;
        e_off  = ($signed({2'b00, ts_t2}) - $signed({2'b00, ts_t1})) - e_ow -
                 $signed({34'd0, cfg_fixed_tx}) - sa;
        e_good = (r >= 0);
      end
      if (pend) begin
        logic [79:0] sum, mn, mx, n;
        sum = '0; mn = '1; mx = '0; n = '0;
        foreach (q_rtt[k]) begin
          if (q_rtt[k] >= 0) begin
            n++;
            sum = sum + 80'(q_rtt[k][64:0]);
            if (80'(q_rtt[k][64:0]) < mn) mn = 80'(q_rtt[k][64:0]);
            if (80'(q_rtt[k][64:0]) > mx) mx = 80'(q_rtt[k][64:0]);
          end
        end
        if (n == 0) begin mn = '0; mx = '0; end
        e_cnt = n; e_min = mn; e_max = mx; e_spr = mx - mn;
        e_mean = sum >> cfg_win_log2;
        e_wv = (n != 0) && (n >= 80'(cfg_min_good)) && (e_spr <= 80'(cfg_jitter_max));
        e_done = 1'b1;
        q_rtt.delete();
      end else begin
        e_done = 1'b0;
      end
      if (ts_valid) begin
        q_rtt.push_back(r);
        pend = (q_rtt.size() == (1 << cfg_win_log2));
      end else begin
        pend = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 s_valid", 80'(s_valid), 80'(e_sv));
      if (e_sv) begin
        check("R1 rtt", 80'(s_rtt), 80'(e_rtt));
        check("R2 one_way", 80'(s_one_way), 80'(e_ow));
        check("R3 offset", 80'(s_offset), 80'(e_off));
        check("R4 good", 80'(s_good), 80'(e_good));
      end
      check("R5 win_done", 80'(win_done), 80'(e_done));
      if (e_done) begin
        check(burst_mode ? "R6 count" : "R7 count", 80'(win_count), e_cnt);
        check("R7 mean", 80'(win_mean), e_mean);
        check("R7 min", 80'(win_min), e_min);
        check("R7 max", 80'(win_max), e_max);
        check("R7 spread", 80'(win_spread), e_spr);
        check((e_spr > 80'(cfg_jitter_max)) ? "R9 valid" : "R8 valid", 80'(win_valid), 80'(e_wv));
      end
    end
  end

  task automatic send(input logic [63:0] base, input longint fwd, input longint rt, input longint turn);
    ts_t1 = base;
    ts_t2 = base + 64'(fwd);
    ts_t3 = ts_t2 + 64'(turn);
    ts_t4 = ts_t3 + 64'(rt - fwd);
    ts_valid = 1'b1;
    @(negedge clk);
    ts_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  localparam logic [63:0] B = 64'h0000_1234_0000_0000;
  localparam logic [63:0] H = 64'hF000_0000_0000_0000;

  initial begin
    idle(3);
    // R10 reset state
    check("R10 s_valid", 80'(s_valid), 0);
    check("R10 win_done", 80'(win_done), 0);
    check("R10 win_valid", 80'(win_valid), 0);
    check("R10 s_rtt", 80'(s_rtt), 0);
    check("R10 win_count", 80'(win_count), 0);
    rst_n = 1'b1;
    idle(2);

    // valid window, spaced strobes
    send(B, 400, 800, 50); idle(2);
    send(B + 5000, -300, 850, 70); idle(1);
    send(B + 9000, 450, 900, 33);
    send(H, 410, 820, 11);
    idle(5);
    // spread above limit
    send(B, 400, 800, 50); send(B, 400, 1100, 50);
    send(B, 400, 900, 50); send(B, 400, 950, 50);
    idle(5);
    // spread exactly at limit
    send(B, 400, 700, 50); send(B, 400, 900, 50);
    send(B, 400, 800, 50); send(B, 400, 777, 50);
    idle(5);
    // unusable samples drop the count below minimum
    send(B, 400, -50, 50); send(B, 400, 800, 50);
    send(B, -700, -1, 90); send(B, 400, 810, 50);
    idle(5);
    // back-to-back strobes across windows
    burst_mode = 1'b1;
    for (int k = 0; k < 12; k++) send(B + 64'(k * 100), 300 + k, 600 + 7 * k, 40);
    idle(5);
    burst_mode = 1'b0;
    // single-strobe windows
    cfg_win_log2 = 4'd0; cfg_min_good = 11'd1; idle(2);
    send(B, 100, 300, 5); send(B, 100, 301, 5); send(B, 100, 303, 5);
    idle(5);
    // empty window with zero minimum
    cfg_win_log2 = 4'd1; cfg_min_good = 11'd0; idle(2);
    send(B, 100, -3, 5); send(B, 100, -9, 5);
    idle(5);
    // wider window with asymmetry change
    cfg_win_log2 = 4'd3; cfg_min_good = 11'd8; cfg_jitter_max = 65'd1000;
    cfg_asym = 32'sd25; cfg_fixed_tx = 32'd7; idle(2);
    for (int k = 0; k < 8; k++) begin
      send(H + 64'(k * 9000), -250 + 61 * k, 1500 + 97 * k, 60 + k);
      idle(k % 3);
    end
    idle(6);
    finish_run();
  end
endmodule